// File: doc/BRIEF.md
# Two-Way Write-Through Cache with Snoop Invalidation

This block sits between a processor request port and a shared memory bus. It holds 8-bit data in a two-way set-associative store of 256 sets with 8-byte lines, and it decodes a 16-bit byte address into a 5-bit tag, an 8-bit set index and a 3-bit byte offset. Both ways of the addressed set are compared in the same cycle. A read hit is answered from the local store and causes no bus traffic.

On a read miss the block asks memory for an 8-beat burst that starts at the aligned line address. It writes each beat into the chosen way, and it returns the requested byte to the processor in the cycle after that byte's beat arrives, while the rest of the line is still arriving. Every processor write goes to memory. A write that hits also updates the local copy. A write that misses does not allocate a line.

One use bit per line selects the victim. Another bus master's write, seen on the snoop input, drops any local copy of that line, including a line that is being filled at that moment. Addresses whose top bit is set are never cached.

Top module: `wt_snoop_cache`

## Requirements
- R1: A read whose tag matches a valid line in either way of its set returns that line's byte in the cycle after acceptance and issues no memory request.
- R2: Each reference to a line (a read hit, a write hit or a completed fill) sets that line's use bit to 1 and clears the use bit of the other line in the set.
- R3: A cacheable read miss replaces the way whose use bit is 0. When both use bits are 0, way 0 is replaced.
- R4: A write hit updates the cached byte and issues exactly one memory write with the same address and data.
- R5: A write miss issues exactly one memory write and leaves the cache contents unchanged, so a later read of that address misses.
- R6: A cacheable read miss issues one burst read (burst = 1) at the line address with offset bits zero. It accepts 8 beats that carry offsets 0 to 7 in order, and it returns the requested byte one cycle after the beat at that byte's offset.
- R7: A snoop whose address lies in a valid cached line invalidates that line. A snoop to any other line leaves the cache unchanged.
- R8: An address with bit 15 = 1 is never cached. Every read of such an address issues a single-beat read (burst = 0), and every write of such an address issues a single write.
- R9: A snoop to the line under fill lets the fill complete and still returns the requested byte, but it leaves that line invalid.
- R10: After reset, cpu_req_ready = 1 and no response or memory request is active. The block accepts a request only while it is idle, and it gives exactly one response per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Block is idle and accepts a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 16 | Byte address |
| cpu_req_wdata | input | 8 | Write data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | 8 | Read data (echoes the data for writes) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_burst | output | 1 | 1 = 8-beat line read, 0 = single access |
| mem_req_addr | output | 16 | Memory byte address |
| mem_req_wdata | output | 8 | Memory write data |
| mem_rsp_valid | input | 1 | Read beat valid |
| mem_rsp_rdata | input | 8 | Read beat data |
| snp_valid | input | 1 | Another master writes snp_addr |
| snp_addr | input | 16 | Snooped write address |

## Verification
A wrong tag, valid bit or use bit does not show up when it goes wrong. It shows up on the next access to that set, either as a memory request where none should appear or as missing traffic with stale data. The bench therefore counts memory requests around every access and reads every line back after it is set up. A victim chosen wrongly shows up only one miss later, as an extra refill of the line that should have stayed. A fill that was killed by a snoop but still marked valid shows up as a silent hit on the next read.

// File: rtl/snc_pkg.sv
// Shared types for the snooping write-through cache.
// Assumes two ways; the controller states are listed here.
package snc_pkg;
    localparam int WAYS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_REQ,
        ST_FILL,
        ST_NC_REQ,
        ST_NC_WAIT,
        ST_WR_REQ
    } state_t;
endpackage

// File: rtl/snc_tags.sv
// Tag and valid store for both ways.
// Compares both ways of one set for the processor and, in parallel,
// for the snoop port. A snoop match clears the valid bit. The snoop
// clear takes priority over a fill completion in the same cycle.
// Assumes alloc and fill never target the same line in one cycle.
module snc_tags #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [1:0]       lk_hit,
    input  logic             sn_en,
    input  logic [IDX_W-1:0] sn_idx,
    input  logic [TAG_W-1:0] sn_tag,
    input  logic             alloc_en,
    input  logic             alloc_way,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             fill_en,
    input  logic             fill_way,
    input  logic [IDX_W-1:0] fill_idx
);
    localparam int SETS = 1 << IDX_W;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [SETS-1:0]  vld_q;
        logic [TAG_W-1:0] tag_q [SETS];
        logic             sn_hit;

        assign lk_hit[w] = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        assign sn_hit    = sn_en && vld_q[sn_idx] && (tag_q[sn_idx] == sn_tag);

        // Valid bits: cleared on allocation, set on a clean fill, cleared by a snoop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= '0;
            end else begin
                if (alloc_en && alloc_way == 1'(w)) vld_q[alloc_idx] <= 1'b0;
                if (fill_en && fill_way == 1'(w))   vld_q[fill_idx]  <= 1'b1;
                if (sn_hit)                         vld_q[sn_idx]    <= 1'b0;
            end
        end

        // Tags: written once when a line is allocated for a fill.
        always_ff @(posedge clk) begin
            if (alloc_en && alloc_way == 1'(w)) tag_q[alloc_idx] <= alloc_tag;
        end

        AST_SNOOP_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
            sn_hit |=> !vld_q[$past(sn_idx)]); // R7
    end
endmodule

// File: rtl/snc_use.sv
// One use bit per line for two-way replacement.
// A reference sets the referenced line's bit and clears its partner's bit.
// The victim is the way whose bit is 0; way 0 wins when both bits are 0.
module snc_use #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             ref_way,
    input  logic [IDX_W-1:0] ref_idx,
    input  logic [IDX_W-1:0] vic_idx,
    output logic             victim
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] use0_q;
    logic [SETS-1:0] use1_q;

    // Use bits: the pair of a referenced set is rewritten as complements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use0_q <= '0;
            use1_q <= '0;
        end else if (ref_en) begin
            use0_q[ref_idx] <= !ref_way;
            use1_q[ref_idx] <= ref_way;
        end
    end

    assign victim = use0_q[vic_idx];

    AST_USE_PAIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ref_en |=> (use1_q[$past(ref_idx)] == $past(ref_way)) &&
                   (use0_q[$past(ref_idx)] != use1_q[$past(ref_idx)])); // R2
endmodule

// File: rtl/snc_data.sv
// Line data for both ways, one packed line per set.
// Provides one combinational byte read port and one byte write port.
// Assumes fill beats and write hits never use the write port in the same cycle.
module snc_data #(
    parameter int IDX_W  = 8,
    parameter int OFF_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rd_way,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_byte,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_byte
);
    localparam int SETS   = 1 << IDX_W;
    localparam int LINE_W = DATA_W << OFF_W;

    logic [1:0][LINE_W-1:0] rline;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [LINE_W-1:0] line_q [SETS];

        // Byte write into the selected line of this way.
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w))
                line_q[wr_idx][int'(wr_off)*DATA_W +: DATA_W] <= wr_byte;
        end

        assign rline[w] = line_q[rd_idx];
    end

    assign rd_byte = rline[rd_way][int'(rd_off)*DATA_W +: DATA_W];
endmodule

// File: rtl/wt_snoop_cache.sv
// Two-way write-through cache controller with snoop invalidation.
// Serves read hits from the local store. It fills a line on a read miss
// and forwards the requested byte during the fill. It writes every store
// through to memory without allocating on a miss. It never caches
// addresses whose top bit is set.
// Assumes memory returns burst beats in offset order, one per mem_rsp_valid.
module wt_snoop_cache
    import snc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 3,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic              mem_req_burst,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int BLK_W = ADDR_W - OFF_W;

    state_t            st_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic              fill_way_q;
    logic [OFF_W-1:0]  beat_q;
    logic              kill_q;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_data_q;

    // Address fields of the incoming request and of the held request.
    logic [OFF_W-1:0] c_off, r_off;
    logic [IDX_W-1:0] c_idx, r_idx, s_idx;
    logic [TAG_W-1:0] c_tag, s_tag;
    logic             c_nc;
    assign c_off = cpu_req_addr[OFF_W-1:0];
    assign c_idx = cpu_req_addr[OFF_W +: IDX_W];
    assign c_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign c_nc  = cpu_req_addr[ADDR_W-1];
    assign r_off = req_addr_q[OFF_W-1:0];
    assign r_idx = req_addr_q[OFF_W +: IDX_W];
    assign s_idx = IDX_W'(snp_addr >> OFF_W);
    assign s_tag = snp_addr[ADDR_W-1 -: TAG_W];

    logic [1:0]        lk_hit;
    logic              hit, hit_way, victim, accept, fill_last;
    logic              snp_on_blk, kill_now;
    logic [DATA_W-1:0] rd_byte;
    logic [BLK_W-1:0]  cur_blk;

    assign cpu_req_ready = (st_q == ST_IDLE);
    assign accept        = cpu_req_valid && cpu_req_ready;
    assign hit           = (|lk_hit) && !c_nc;
    assign hit_way       = lk_hit[1];
    assign fill_last     = (st_q == ST_FILL) && mem_rsp_valid && (beat_q == '1);
    assign cur_blk       = (st_q == ST_IDLE) ? BLK_W'(cpu_req_addr >> OFF_W)
                                             : BLK_W'(req_addr_q >> OFF_W);
    assign snp_on_blk    = snp_valid && (BLK_W'(snp_addr >> OFF_W) == cur_blk);
    assign kill_now      = kill_q || snp_on_blk;

    snc_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(c_idx), .lk_tag(c_tag), .lk_hit(lk_hit),
        .sn_en(snp_valid), .sn_idx(s_idx), .sn_tag(s_tag),
        .alloc_en(accept && !cpu_req_write && !c_nc && !hit),
        .alloc_way(victim), .alloc_idx(c_idx), .alloc_tag(c_tag),
        .fill_en(fill_last && !kill_now), .fill_way(fill_way_q), .fill_idx(r_idx)
    );

    snc_use #(.IDX_W(IDX_W)) use_i (
        .clk(clk), .rst_n(rst_n),
        .ref_en((accept && hit) || fill_last),
        .ref_way(fill_last ? fill_way_q : hit_way),
        .ref_idx(fill_last ? r_idx : c_idx),
        .vic_idx(c_idx), .victim(victim)
    );

    snc_data #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) data_i (
        .clk(clk),
        .rd_way(hit_way), .rd_idx(c_idx), .rd_off(c_off), .rd_byte(rd_byte),
        .wr_en((accept && hit && cpu_req_write) || ((st_q == ST_FILL) && mem_rsp_valid)),
        .wr_way((st_q == ST_FILL) ? fill_way_q : hit_way),
        .wr_idx((st_q == ST_FILL) ? r_idx : c_idx),
        .wr_off((st_q == ST_FILL) ? beat_q : c_off),
        .wr_byte((st_q == ST_FILL) ? mem_rsp_rdata : cpu_req_wdata)
    );

    // Memory request drive, decoded from the controller state.
    assign mem_req_valid = (st_q == ST_FILL_REQ) || (st_q == ST_NC_REQ) || (st_q == ST_WR_REQ);
    assign mem_req_write = (st_q == ST_WR_REQ);
    assign mem_req_burst = (st_q == ST_FILL_REQ);
    assign mem_req_addr  = mem_req_burst ? {req_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : req_addr_q;
    assign mem_req_wdata = req_wdata_q;
    assign cpu_rsp_valid = rsp_valid_q;
    assign cpu_rsp_rdata = rsp_data_q;

    // Controller: request capture, fill beat counting, responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            fill_way_q  <= 1'b0;
            beat_q      <= '0;
            kill_q      <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            kill_q      <= (st_q == ST_IDLE) ? (accept && snp_on_blk) : kill_now;
            case (st_q)
                ST_IDLE: if (accept) begin
                    req_addr_q  <= cpu_req_addr;
                    req_wdata_q <= cpu_req_wdata;
                    fill_way_q  <= victim;
                    if (cpu_req_write) begin
                        st_q <= ST_WR_REQ;
                    end else if (c_nc) begin
                        st_q <= ST_NC_REQ;
                    end else if (hit) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= rd_byte;
                    end else begin
                        st_q <= ST_FILL_REQ;
                    end
                end
                ST_FILL_REQ: if (mem_req_ready) begin
                    st_q   <= ST_FILL;
                    beat_q <= '0;
                end
                ST_FILL: if (mem_rsp_valid) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == r_off) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= mem_rsp_rdata;
                    end
                    if (beat_q == '1) st_q <= ST_IDLE;
                end
                ST_NC_REQ: if (mem_req_ready) st_q <= ST_NC_WAIT;
                ST_NC_WAIT: if (mem_rsp_valid) begin
                    rsp_valid_q <= 1'b1;
                    rsp_data_q  <= mem_rsp_rdata;
                    st_q        <= ST_IDLE;
                end
                ST_WR_REQ: if (mem_req_ready) begin
                    rsp_valid_q <= 1'b1;
                    rsp_data_q  <= req_wdata_q;
                    st_q        <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_HIT_AT_MOST_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit)); // R1
    AST_WRITE_GOES_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_req_write) |=> (mem_req_valid && mem_req_write)); // R4
    AST_BURST_IS_ALIGNED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_burst) |-> (!mem_req_write && mem_req_addr[OFF_W-1:0] == '0)); // R6
    AST_UNCACHED_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_addr[ADDR_W-1]) |-> !mem_req_burst); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cpu_req_ready); // R10
endmodule

// File: tb/wt_snoop_cache_tb_top.sv
`timescale 1ns/1ps
module wt_snoop_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [15:0] cpu_req_addr = '0;
    logic [7:0]  cpu_req_wdata = '0;
    logic        cpu_req_ready, cpu_rsp_valid;
    logic [7:0]  cpu_rsp_rdata;
    logic        mem_req_valid, mem_req_write, mem_req_burst;
    logic [15:0] mem_req_addr;
    logic [7:0]  mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_rdata = '0;
    logic        snp_valid = 1'b0;
    logic [15:0] snp_addr = '0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    wt_snoop_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_ready(1'b1), .mem_req_write(mem_req_write),
        .mem_req_burst(mem_req_burst), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .snp_valid(snp_valid), .snp_addr(snp_addr)
    );

    // Memory model: written bytes are kept, all other bytes follow a formula.
    logic [7:0] mem_w [int];
    int         req_cnt = 0, beats_taken = 0, pend_n = 0, pend_idx = 0;
    logic [15:0] pend_base = '0, last_addr = '0;
    logic        last_write = 1'b0, last_burst = 1'b0;
    logic [7:0]  last_wdata = '0;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [7:0] mrd(input logic [15:0] a);
        if (mem_w.exists(int'(a))) return mem_w[int'(a)];
        return pat(a);
    endfunction

    function automatic logic [15:0] mk(input int tag, input int idx, input int off);
        return {5'(tag), 8'(idx), 3'(off)};
    endfunction

    always @(posedge clk) begin
        if (mem_rsp_valid) begin
            pend_idx    <= pend_idx + 1;
            pend_n      <= pend_n - 1;
            beats_taken <= beats_taken + 1;
        end
        if (mem_req_valid) begin
            req_cnt    <= req_cnt + 1;
            last_addr  <= mem_req_addr;
            last_write <= mem_req_write;
            last_burst <= mem_req_burst;
            last_wdata <= mem_req_wdata;
            if (mem_req_write) begin
                mem_w[int'(mem_req_addr)] = mem_req_wdata;
            end else begin
                pend_base <= mem_req_addr;
                pend_idx  <= 0;
                pend_n    <= mem_req_burst ? 8 : 1;
            end
        end
    end

    always @(negedge clk) begin
        mem_rsp_valid <= (pend_n > 0);
        mem_rsp_rdata <= (pend_n > 0) ? mrd(pend_base + 16'(pend_idx)) : 8'h00;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // One processor access; optional snoop pulse at a given cycle after acceptance.
    task automatic cpu_op(input logic wr, input logic [15:0] a, input logic [7:0] wd,
                          input int snp_at, input logic [15:0] snp_a,
                          output logic [7:0] rd, output int nreq, output int beats_at,
                          output int got);
        int r0 = req_cnt;
        int b0 = beats_taken;
        rd = 8'h00; beats_at = 0; got = 0;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
        @(posedge clk);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (i == 0) cpu_req_valid = 1'b0;
            snp_valid = (i == snp_at);
            snp_addr  = snp_a;
            if (cpu_rsp_valid) begin
                got++;
                rd = cpu_rsp_rdata;
                beats_at = beats_taken - b0;
            end
            if (got > 0 && cpu_req_ready && !snp_valid) break;
        end
        snp_valid = 1'b0;
        nreq = req_cnt - r0;
    endtask

    task automatic snoop(input logic [15:0] a, input logic upd, input logic [7:0] v);
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = a;
        if (upd) mem_w[int'(a)] = v;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0]  rd;
        int          nreq, bt, got;
        logic [15:0] a;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 ready after reset", int'(cpu_req_ready), 1);
        chk("R10 no response after reset", int'(cpu_rsp_valid), 0);
        chk("R10 no mem request after reset", int'(mem_req_valid), 0);
        rst_n = 1'b1;

        // R6 forwarding sweep over every offset, then R1 hits over the whole line
        for (int off = 0; off < 8; off++) begin
            a = mk(1, 16 + off, off);
            cpu_op(1'b0, a, 8'h00, -1, 16'h0, rd, nreq, bt, got);
            chk("R6 one request per miss", nreq, 1);
            chk("R6 burst flag", int'(last_burst), 1);
            chk("R6 aligned line address", int'(last_addr), int'(mk(1, 16 + off, 0)));
            chk("R6 forwarded byte", int'(rd), int'(mrd(a)));
            chk("R6 forwarded after its own beat", bt, off + 1);
            chk("R10 one response", got, 1);
            for (int o = 0; o < 8; o++) begin
                a = mk(1, 16 + off, o);
                cpu_op(1'b0, a, 8'h00, -1, 16'h0, rd, nreq, bt, got);
                chk("R1 hit no traffic", nreq, 0);
                chk("R1 hit data", int'(rd), int'(mrd(a)));
            end
        end

        // R1 both ways; R2/R3 use-bit victim choice in set 40
        cpu_op(1'b0, mk(2, 40, 3), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        cpu_op(1'b0, mk(3, 40, 5), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        cpu_op(1'b0, mk(3, 40, 5), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R1 way holding second line hits", nreq, 0);
        cpu_op(1'b0, mk(2, 40, 3), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R1 way holding first line hits", nreq, 0);
        chk("R1 first line data", int'(rd), int'(mrd(mk(2, 40, 3))));
        cpu_op(1'b0, mk(4, 40, 1), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R3 third tag misses", nreq, 1);
        cpu_op(1'b0, mk(2, 40, 3), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R2 recently used line kept", nreq, 0);
        cpu_op(1'b0, mk(3, 40, 5), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R3 line with use bit 0 evicted", nreq, 1);
        cpu_op(1'b0, mk(2, 40, 3), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R2 fill marks partner unused, kept line hits", nreq, 0);

        // R4 write hit
        cpu_op(1'b0, mk(5, 60, 2), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        cpu_op(1'b1, mk(5, 60, 2), 8'h3C, -1, 16'h0, rd, nreq, bt, got);
        chk("R4 one memory write", nreq, 1);
        chk("R4 write flag", int'(last_write), 1);
        chk("R4 write address", int'(last_addr), int'(mk(5, 60, 2)));
        chk("R4 write data", int'(last_wdata), 8'h3C);
        chk("R10 write response", got, 1);
        cpu_op(1'b0, mk(5, 60, 2), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R4 written line still hits", nreq, 0);
        chk("R4 cached copy updated", int'(rd), 8'h3C);
        cpu_op(1'b0, mk(5, 60, 7), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R4 neighbour byte unchanged", int'(rd), int'(pat(mk(5, 60, 7))));

        // R5 write miss, no allocation
        cpu_op(1'b1, mk(6, 61, 4), 8'h77, -1, 16'h0, rd, nreq, bt, got);
        chk("R5 one memory write", nreq, 1);
        chk("R5 write address", int'(last_addr), int'(mk(6, 61, 4)));
        cpu_op(1'b0, mk(6, 61, 4), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R5 later read misses", nreq, 1);
        chk("R5 memory holds written byte", int'(rd), 8'h77);

        // R7 snoop invalidation and non-matching snoops
        snoop(mk(7, 60, 6), 1'b0, 8'h0);
        snoop(mk(5'h11, 60, 6), 1'b0, 8'h0);
        cpu_op(1'b0, mk(5, 60, 2), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R7 other-tag snoop leaves line", nreq, 0);
        snoop(mk(5, 60, 6), 1'b1, 8'h99);
        cpu_op(1'b0, mk(5, 60, 6), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R7 snooped line refetched", nreq, 1);
        chk("R7 new memory value seen", int'(rd), 8'h99);

        // R9 snoop on the line under fill
        cpu_op(1'b0, mk(8, 70, 5), 8'h0, 2, mk(8, 70, 0), rd, nreq, bt, got);
        chk("R9 fill still requested once", nreq, 1);
        chk("R9 byte still forwarded", int'(rd), int'(mrd(mk(8, 70, 5))));
        cpu_op(1'b0, mk(8, 70, 5), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R9 killed line left invalid", nreq, 1);
        cpu_op(1'b0, mk(8, 70, 5), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R9 clean refill is valid", nreq, 0);
        cpu_op(1'b0, mk(9, 71, 0), 8'h0, 3, mk(9, 72, 0), rd, nreq, bt, got);
        cpu_op(1'b0, mk(9, 71, 0), 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R9 snoop to other line keeps fill", nreq, 0);

        // R8 uncached region
        a = mk(5'h11, 33, 6);
        for (int k = 0; k < 2; k++) begin
            cpu_op(1'b0, a, 8'h0, -1, 16'h0, rd, nreq, bt, got);
            chk("R8 uncached read goes to memory", nreq, 1);
            chk("R8 single beat", int'(last_burst), 0);
            chk("R8 uncached data", int'(rd), int'(mrd(a)));
        end
        cpu_op(1'b1, a, 8'h5E, -1, 16'h0, rd, nreq, bt, got);
        chk("R8 uncached write single", nreq, 1);
        cpu_op(1'b0, a, 8'h0, -1, 16'h0, rd, nreq, bt, got);
        chk("R8 uncached read after write", int'(rd), 8'h5E);
        chk("R8 still not cached", nreq, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule